// File: doc/BRIEF.md
# Parallel-Bus Quad DAC Register Write Interface

This block is the digital front end of a four-channel voltage DAC loaded over a parallel bus. A host drives a 10-bit data word, a mode pin and a two-bit channel address, then strobes active-low chip select and write. On the rising edge of write, the word goes to one of four kinds of register: a channel's main DAC data register, a channel's sub DAC data register, a channel control register, or the single system control register. Every DAC is double buffered. Data registers feed DAC registers, and only the DAC registers reach the analog side.

The DAC registers take the buffered data in one of two ways. The host can take the active-low load strobe low, which copies all channels at once. Or the load strobe can be low when write rises, which updates the written channel automatically. An asynchronous clear input, and clear commands carried inside control words, return main DACs to a code chosen by the coding mode and a clear-select bit. The asynchronous clear also centres the sub DACs. All bus pins are brought into the system clock domain through two-flop synchronizers.

A small state machine follows the write strobe. Its states are `ST_IDLE` (write high), `ST_CAPT` (chip select and write low, bus being captured), `ST_COMMIT` (a one-cycle register update) and `ST_DROP` (write low without chip select, ignored until write rises). Its transitions are:
- IDLE→CAPT on write low with chip select low.
- IDLE→DROP on write low with chip select high.
- CAPT→COMMIT on write high.
- CAPT→DROP on chip select high while write is low.
- COMMIT→IDLE always.
- DROP→IDLE on write high.

Top module: `pdac_wr_if`

## Requirements
- R1: A register changes only for a write edge during which chip select was low while write was low. A write with chip select high changes no register.
- R2: With mode high, the full 10-bit word (bit 9 most significant) is loaded into the main DAC data register of the channel named by the address.
- R3: With mode low and data bit 9 set, bits 3:0 load the system register, and the address is ignored. The system register fields are: bit 0 twos-complement coding, bit 1 clear-to-bias select, bit 2 system standby, bit 3 power-down.
- R4: With mode low, bit 9 clear and bit 8 set, bits 7:0 load the addressed channel's sub DAC data register.
- R5: With mode low and bits 9 and 8 clear, bits 2:0 load the addressed channel control register. Bit 0 is channel standby and bits 2:1 are the bias source select. Such a write leaves other channels and the system register unchanged.
- R6: Data registers are buffered. DAC outputs hold until the load strobe is low, and a low load strobe copies every channel's main and sub data into its DAC registers.
- R7: If the load strobe is low at the write rising edge, the written channel's DAC register takes the new value with no separate load pulse.
- R8: A low clear input sets every main data and DAC register to the clear code and every sub register to 0x80. The clear code is 0x200 when (coding XOR clear-select) is 1, and 0x000 otherwise.
- R9: A system write with bit 4 set clears all main DACs to the clear code of the word being written, leaving sub DACs alone. A channel control write with bit 3 set clears that channel's main DAC to the clear code of the current system register.
- R10: One write strobe produces exactly one register update, however long write is held low.
- R11: After reset, main codes are 0x000, sub codes are 0x80, and the system and channel control registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| mode | input | 1 | 1 = main DAC data, 0 = control target |
| addr | input | AW (2) | Channel address |
| data | input | DW (10) | Data bus, bit 9 MSB |
| ldac_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Clear, active low |
| main_code | output | NCH*DW (40) | Main DAC register per channel, channel 0 in low bits |
| sub_code | output | NCH*SW (32) | Sub DAC register per channel |
| sys_ctrl | output | 4 | System control register |
| ch_ctrl | output | NCH*3 (12) | Channel control registers {bias[1:0], standby} |

## Verification
The hardest situation to create is the overlap of a write with the load strobe. A write edge that lands while the load strobe is low must both update the addressed buffer and pass it through in the same update. Clear commands embedded in control words must also interact correctly with buffered data that has not yet been loaded. The stimulus reaches these cases by holding the load strobe low across whole write cycles, and by interleaving random writes, load pulses and clear pulses. Buffered data is therefore frequently pending when a clear or a load-while-writing arrives. Directed steps cover the chip-select-high write, an extended write pulse and both clear codes.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPT,
        ST_COMMIT,
        ST_DROP
    } wr_state_e;

    localparam int SYS_SEL_BIT = 9;
    localparam int SUB_SEL_BIT = 8;
    localparam int SW_CLR_BIT  = 4;
    localparam int CH_CLR_BIT  = 3;
    localparam int SYS_FIELDS  = 4;
    localparam int CH_FIELDS   = 3;
endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
    parameter int         W  = 1,
    parameter logic [W-1:0] RV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RV;
            sync_q <= RV;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/pdac_wr_fsm.sv
module pdac_wr_fsm
    import pdac_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_s,
    input  logic          cs_s,
    input  logic          mode_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic          ldac_s,
    output logic          commit,
    output logic          h_mode,
    output logic [AW-1:0] h_addr,
    output logic [DW-1:0] h_data,
    output logic          h_ldac
);
    wr_state_e state_q;
    wr_state_e state_n;
    logic      capture;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!wr_s && !cs_s)     state_n = ST_CAPT;
                else if (!wr_s && cs_s) state_n = ST_DROP;
            end
            ST_CAPT: begin
                if (wr_s)      state_n = ST_COMMIT;
                else if (cs_s) state_n = ST_DROP;
            end
            ST_COMMIT: state_n = ST_IDLE;
            ST_DROP: begin
                if (wr_s) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign capture = ((state_q == ST_IDLE) || (state_q == ST_CAPT)) && !wr_s && !cs_s;
    assign commit  = (state_q == ST_COMMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_mode <= 1'b0;
            h_addr <= '0;
            h_data <= '0;
            h_ldac <= 1'b1;
        end else if (capture) begin
            h_mode <= mode_s;
            h_addr <= addr_s;
            h_data <= data_s;
            h_ldac <= ldac_s;
        end
    end
endmodule

// File: rtl/pdac_regbank.sv
module pdac_regbank
    import pdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 10,
    parameter int SW  = 8,
    parameter int AW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic                     h_mode,
    input  logic [AW-1:0]            h_addr,
    input  logic [DW-1:0]            h_data,
    input  logic                     h_ldac,
    input  logic                     ldac_s,
    input  logic                     clr_s,
    output logic [NCH*DW-1:0]        main_code,
    output logic [NCH*SW-1:0]        sub_code,
    output logic [SYS_FIELDS-1:0]    sys_ctrl,
    output logic [NCH*CH_FIELDS-1:0] ch_ctrl
);
    localparam logic [DW-1:0] MAIN_MID = {1'b1, {(DW-1){1'b0}}};
    localparam logic [SW-1:0] SUB_MID  = {1'b1, {(SW-1){1'b0}}};

    function automatic logic [DW-1:0] clr_code(input logic twos, input logic to_bias);
        return (twos ^ to_bias) ? MAIN_MID : '0;
    endfunction

    logic [SYS_FIELDS-1:0] sys_q;
    logic                  sys_wr, ch_wr, sub_wr, main_wr, sw_clr;
    logic [DW-1:0]         cmd_clr_val;
    logic [DW-1:0]         pin_clr_val;

    assign sys_wr  = commit && !h_mode && h_data[SYS_SEL_BIT];
    assign sub_wr  = commit && !h_mode && !h_data[SYS_SEL_BIT] && h_data[SUB_SEL_BIT];
    assign ch_wr   = commit && !h_mode && !h_data[SYS_SEL_BIT] && !h_data[SUB_SEL_BIT];
    assign main_wr = commit && h_mode;
    assign sw_clr  = sys_wr && h_data[SW_CLR_BIT];

    assign cmd_clr_val = sys_wr ? clr_code(h_data[0], h_data[1]) : clr_code(sys_q[0], sys_q[1]);
    assign pin_clr_val = clr_code(sys_q[0], sys_q[1]);

    always_ff @(posedge clk) begin
        if (!rst_n)      sys_q <= '0;
        else if (sys_wr) sys_q <= h_data[SYS_FIELDS-1:0];
    end

    assign sys_ctrl = sys_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DW-1:0]        dm_q, dm_n, dacm_q, dacm_n;
        logic [SW-1:0]        ds_q, ds_n, dacs_q, dacs_n;
        logic [CH_FIELDS-1:0] cc_q, cc_n;
        logic                 sel;

        assign sel = (h_addr == AW'(c));

        always_comb begin
            dm_n   = dm_q;
            dacm_n = dacm_q;
            ds_n   = ds_q;
            dacs_n = dacs_q;
            cc_n   = cc_q;
            if (!clr_s) begin
                dm_n   = pin_clr_val;
                dacm_n = pin_clr_val;
                ds_n   = SUB_MID;
                dacs_n = SUB_MID;
            end else begin
                if (main_wr && sel) dm_n = h_data;
                if (sub_wr && sel)  ds_n = h_data[SW-1:0];
                if (ch_wr && sel)   cc_n = h_data[CH_FIELDS-1:0];
                if (!ldac_s || ((main_wr || sub_wr) && sel && !h_ldac)) begin
                    dacm_n = dm_n;
                    dacs_n = ds_n;
                end
                if (sw_clr || (ch_wr && sel && h_data[CH_CLR_BIT])) begin
                    dm_n   = cmd_clr_val;
                    dacm_n = cmd_clr_val;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dm_q   <= clr_code(1'b0, 1'b0);
                dacm_q <= clr_code(1'b0, 1'b0);
                ds_q   <= SUB_MID;
                dacs_q <= SUB_MID;
                cc_q   <= '0;
            end else begin
                dm_q   <= dm_n;
                dacm_q <= dacm_n;
                ds_q   <= ds_n;
                dacs_q <= dacs_n;
                cc_q   <= cc_n;
            end
        end

        assign main_code[c*DW +: DW]               = dacm_q;
        assign sub_code[c*SW +: SW]                = dacs_q;
        assign ch_ctrl[c*CH_FIELDS +: CH_FIELDS]   = cc_q;
    end
endmodule

// File: rtl/pdac_wr_if.sv
module pdac_wr_if
    import pdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 10,
    parameter int SW  = 8,
    parameter int AW  = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     mode,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            data,
    input  logic                     ldac_n,
    input  logic                     clr_n,
    output logic [NCH*DW-1:0]        main_code,
    output logic [NCH*SW-1:0]        sub_code,
    output logic [SYS_FIELDS-1:0]    sys_ctrl,
    output logic [NCH*CH_FIELDS-1:0] ch_ctrl
);
    localparam int BUS_W = 1 + AW + DW;

    logic             wr_s, cs_s, ldac_s, clr_s;
    logic [BUS_W-1:0] bus_s;
    logic             mode_s;
    logic [AW-1:0]    addr_s;
    logic [DW-1:0]    data_s;

    logic             commit, h_mode, h_ldac;
    logic [AW-1:0]    h_addr;
    logic [DW-1:0]    h_data;

    pdac_sync #(.W(4), .RV(4'hF)) u_sync_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({wr_n, cs_n, ldac_n, clr_n}),
        .dout ({wr_s, cs_s, ldac_s, clr_s})
    );

    pdac_sync #(.W(BUS_W), .RV('0)) u_sync_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mode, addr, data}),
        .dout (bus_s)
    );

    assign {mode_s, addr_s, data_s} = bus_s;

    pdac_wr_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_s  (wr_s),
        .cs_s  (cs_s),
        .mode_s(mode_s),
        .addr_s(addr_s),
        .data_s(data_s),
        .ldac_s(ldac_s),
        .commit(commit),
        .h_mode(h_mode),
        .h_addr(h_addr),
        .h_data(h_data),
        .h_ldac(h_ldac)
    );

    pdac_regbank #(.NCH(NCH), .DW(DW), .SW(SW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .h_mode   (h_mode),
        .h_addr   (h_addr),
        .h_data   (h_data),
        .h_ldac   (h_ldac),
        .ldac_s   (ldac_s),
        .clr_s    (clr_s),
        .main_code(main_code),
        .sub_code (sub_code),
        .sys_ctrl (sys_ctrl),
        .ch_ctrl  (ch_ctrl)
    );
endmodule

// File: rtl/pdac_wr_chk.sv
module pdac_wr_chk #(
    parameter int NCH = 4,
    parameter int DW  = 10,
    parameter int SW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit,
    input logic              wr_s,
    input logic              ldac_s,
    input logic              clr_s,
    input logic [NCH*DW-1:0] main_code,
    input logic [NCH*SW-1:0] sub_code,
    input logic [3:0]        sys_ctrl,
    input logic [NCH*3-1:0]  ch_ctrl
);
    localparam logic [SW-1:0] SUB_MID = {1'b1, {(SW-1){1'b0}}};

    p_single_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    p_commit_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !$past(wr_s, 2));

    p_hold_without_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_s && clr_s && !commit) |=> ($stable(main_code) && $stable(sub_code)));

    p_clear_sub_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (sub_code == {NCH{SUB_MID}}));

    p_sys_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(sys_ctrl));

    p_ch_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ch_ctrl));
endmodule

bind pdac_wr_if pdac_wr_chk #(.NCH(NCH), .DW(DW), .SW(SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .wr_s     (wr_s),
    .ldac_s   (ldac_s),
    .clr_s    (clr_s),
    .main_code(main_code),
    .sub_code (sub_code),
    .sys_ctrl (sys_ctrl),
    .ch_ctrl  (ch_ctrl)
);

// File: tb/sim_pdac_wr_if.sv
module sim_pdac_wr_if;
    localparam int NCH = 4;
    localparam int DW  = 10;
    localparam int SW  = 8;
    localparam int AW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1, wr_n = 1'b1, mode = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     data = '0;
    logic [NCH*DW-1:0] main_code;
    logic [NCH*SW-1:0] sub_code;
    logic [3:0]        sys_ctrl;
    logic [NCH*3-1:0]  ch_ctrl;

    int n_chk = 0;
    int n_fail = 0;

    logic [DW-1:0] m_dat [NCH];
    logic [DW-1:0] m_dac [NCH];
    logic [SW-1:0] s_dat [NCH];
    logic [SW-1:0] s_dac [NCH];
    logic [2:0]    m_ch  [NCH];
    logic [3:0]    m_sys;

    always #5 clk = ~clk;

    pdac_wr_if #(.NCH(NCH), .DW(DW), .SW(SW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .mode(mode),
        .addr(addr), .data(data), .ldac_n(ldac_n), .clr_n(clr_n),
        .main_code(main_code), .sub_code(sub_code), .sys_ctrl(sys_ctrl), .ch_ctrl(ch_ctrl)
    );

    // clear code from R8: 0x200 when coding XOR clear-select, else 0x000
    function automatic logic [DW-1:0] exp_clr(input logic [3:0] s);
        return (s[0] != s[1]) ? 10'h200 : 10'h000;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " main"}, 64'(main_code[c*DW +: DW]), 64'(m_dac[c]));
            chk({tag, " sub"},  64'(sub_code[c*SW +: SW]),  64'(s_dac[c]));
            chk({tag, " chctl"}, 64'(ch_ctrl[c*3 +: 3]),    64'(m_ch[c]));
        end
        chk({tag, " sys"}, 64'(sys_ctrl), 64'(m_sys));
    endtask

    task automatic copy_all();
        for (int c = 0; c < NCH; c++) begin
            m_dac[c] = m_dat[c];
            s_dac[c] = s_dat[c];
        end
    endtask

    task automatic do_write(input bit cs_ok, input bit md, input int a,
                            input logic [DW-1:0] d, input bit ld_low, input int hold);
        @(negedge clk);
        mode = md; addr = AW'(a); data = d;
        cs_n = !cs_ok;
        ldac_n = !ld_low;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; ldac_n = 1'b1;
        repeat (8) @(negedge clk);
        if (cs_ok) begin
            if (md) m_dat[a] = d;
            else if (d[9]) begin
                m_sys = d[3:0];
                if (d[4]) for (int c = 0; c < NCH; c++) begin
                    m_dat[c] = exp_clr(m_sys); m_dac[c] = exp_clr(m_sys);
                end
            end else if (d[8]) s_dat[a] = d[7:0];
            else begin
                m_ch[a] = d[2:0];
                if (d[3]) begin m_dat[a] = exp_clr(m_sys); m_dac[a] = exp_clr(m_sys); end
            end
        end
        if (ld_low) copy_all();
    endtask

    task automatic pulse_ldac();
        @(negedge clk); ldac_n = 1'b0;
        repeat (3) @(negedge clk); ldac_n = 1'b1;
        repeat (6) @(negedge clk);
        copy_all();
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_n = 1'b0;
        repeat (3) @(negedge clk); clr_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            m_dat[c] = exp_clr(m_sys); m_dac[c] = exp_clr(m_sys);
            s_dat[c] = 8'h80; s_dac[c] = 8'h80;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin
            m_dat[c] = '0; m_dac[c] = '0; s_dat[c] = 8'h80; s_dac[c] = 8'h80; m_ch[c] = '0;
        end
        m_sys = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R11 reset");

        do_write(1, 1, 1, 10'h155, 0, 4);
        check_all("R6 buffered before load");
        pulse_ldac();
        check_all("R6 load copies");

        do_write(1, 1, 2, 10'h200, 0, 4);
        pulse_ldac();
        check_all("R2 msb main write");

        do_write(0, 1, 2, 10'h3FF, 0, 4);
        pulse_ldac();
        check_all("R1 chip select high ignored");

        do_write(1, 1, 3, 10'h2AA, 1, 4);
        check_all("R7 auto update");

        do_write(1, 0, 0, 10'h15A, 0, 4);
        pulse_ldac();
        check_all("R4 sub write");

        do_write(1, 0, 3, 10'h201, 0, 4);
        check_all("R3 system write twos");

        do_write(1, 0, 2, 10'h005, 0, 4);
        check_all("R5 channel control");

        do_write(1, 1, 3, 10'h0F0, 0, 4);
        do_write(1, 0, 3, 10'h008, 0, 4);
        check_all("R9 channel clear");

        do_write(1, 1, 0, 10'h111, 0, 4);
        pulse_clr();
        check_all("R8 clear to bottom twos");
        pulse_ldac();
        check_all("R8 cleared buffer stays");

        do_write(1, 1, 1, 10'h333, 0, 4);
        do_write(1, 0, 2, 10'h212, 0, 4);
        check_all("R9 system clear offset bias");
        pulse_clr();
        check_all("R8 clear to bias offset");

        do_write(1, 1, 0, 10'h0F0, 1, 40);
        check_all("R10 long write single update");

        for (int i = 0; i < 250; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k < 7)
                do_write(($urandom % 8) != 0, $urandom % 2, int'($urandom % NCH),
                         DW'($urandom), ($urandom % 4) == 0, 2 + int'($urandom % 5));
            else if (k < 9) pulse_ldac();
            else pulse_clr();
            check_all("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule